// File: doc/BRIEF.md
# NOR Flash Write-Command Interpreter

This block sits on the device side of a parallel NOR flash bank. It watches bus write cycles, each made of a word address and a data byte, and turns fixed address/data sequences into actions on a small internal array. Those actions are a timed program of one word and a timed erase of the whole main array. It also switches between modes: a fast program mode that skips the unlock writes, and an overlay mode in which reads and programs reach a separate secured region instead of the main array.

Each command starts with two unlock writes: AAh at word address 555h, then 55h at address 2AAh. The byte that follows at 555h chooses the command. A0h is program setup, 80h is erase setup, 20h enters fast mode, 88h enters the secured overlay and 90h starts the overlay exit. While an embedded operation runs, the ready output is low and every write is ignored. A write that does not fit the sequence in progress drops the interpreter back to read mode. The array only ever clears bits when programmed. Only a chip erase returns them to ones.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, ready is high, the interpreter is in read mode with neither fast mode nor the overlay active, and every word of both regions reads FFh.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then data D at any address A, program word A. The low MAW address bits select the main word and the low SAW bits select the secured word. The result is visible once ready returns high.
- R3: Programming only clears bits: the stored word becomes the old word ANDed with D.
- R4: AAh@555h, 55h@2AAh, 20h@555h enter fast mode. In fast mode, A0h at any address followed by D at address A programs word A, and this can repeat with no further unlock writes.
- R5: In fast mode, every byte except A0h and 90h leaves the mode unchanged and has no effect. 90h followed by 00h, both at any address, leaves fast mode, after which A0h alone no longer starts a program.
- R6: AAh@555h, 55h@2AAh, 88h@555h select the secured overlay. While it is selected, rd_data returns the secured word and programs target the secured region. AAh@555h, 55h@2AAh, 90h@555h, 00h at any address deselect it. Secured contents persist across the overlay being deselected.
- R7: While the overlay is selected, the fast-mode entry sequence is rejected and behaves like a mismatching write.
- R8: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h erase the chip. When the operation completes, every main word reads FFh.
- R9: After the write that completes a program, ready is low for exactly PROG_CYCLES clocks. After the write that completes an erase, ready is low for exactly ERASE_CYCLES clocks.
- R10: Writes made while ready is low have no effect on the array or on the modes.
- R11: Outside fast mode, a write whose address or data does not fit the sequence in progress returns the interpreter to read mode. That write does not start a new sequence.
- R12: Asserting reset during an embedded operation aborts it at once: ready goes high and the interpreter returns to read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_addr | input | MAW | Word address for reads |
| rd_data | output | 8 | Word read from the main array or from the secured region |
| ready | output | 1 | High when idle, low while an embedded operation runs |

## Verification
The assertions assume that wr_en carries at most one write per clock and that reset is the only way an embedded operation ends early. They also assume the program and erase cycle counts are at least one. The stimulus drives wr_en for exactly one clock per write and holds it low between tasks. It deliberately issues complete command sequences while ready is low, so that the ignore path is exercised. It releases reset only on the falling edge of the clock.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int unsigned DW = 8;

  localparam int unsigned ADDR_KEY1 = 'h555;
  localparam int unsigned ADDR_KEY2 = 'h2AA;

  localparam logic [DW-1:0] BYTE_KEY1    = 8'hAA;
  localparam logic [DW-1:0] BYTE_KEY2    = 8'h55;
  localparam logic [DW-1:0] OP_PROGRAM   = 8'hA0;
  localparam logic [DW-1:0] OP_ERASE_SET = 8'h80;
  localparam logic [DW-1:0] OP_ERASE_ALL = 8'h10;
  localparam logic [DW-1:0] OP_FAST_IN   = 8'h20;
  localparam logic [DW-1:0] OP_OVL_IN    = 8'h88;
  localparam logic [DW-1:0] OP_LEAVE     = 8'h90;
  localparam logic [DW-1:0] OP_LEAVE_END = 8'h00;

  typedef enum logic [3:0] {
    ST_READ, ST_KEY1, ST_KEY2, ST_PROG_DATA,
    ST_ERS_SET, ST_ERS_KEY1, ST_ERS_KEY2,
    ST_OVL_LEAVE, ST_FAST_LEAVE
  } seq_state_t;

  function automatic logic [DW-1:0] clear_only(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic int unsigned load_value(input int unsigned cycles);
    return cycles - 1;
  endfunction
endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer
  import nor_cmd_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned ERASE_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  output logic busy,
  output logic done
);
  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_prog) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(load_value(PROG_CYCLES));
    end else if (start_erase) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(load_value(ERASE_CYCLES));
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |=> busy);
  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output logic          prog_go,
  output logic          erase_go,
  output logic          ovl_mode,
  output logic          fast_mode
);
  seq_state_t st_q, st_n;
  logic ovl_q, ovl_n, fast_q, fast_n;
  logic take, at_k1, at_k2;

  assign take  = wr_en && !busy;
  assign at_k1 = (wr_addr == AW'(ADDR_KEY1));
  assign at_k2 = (wr_addr == AW'(ADDR_KEY2));
  assign ovl_mode  = ovl_q;
  assign fast_mode = fast_q;

  always_comb begin
    st_n     = st_q;
    ovl_n    = ovl_q;
    fast_n   = fast_q;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    if (take) begin
      st_n = ST_READ;
      unique case (st_q)
        ST_READ: begin
          if (fast_q) begin
            if (wr_data == OP_PROGRAM)    st_n = ST_PROG_DATA;
            else if (wr_data == OP_LEAVE) st_n = ST_FAST_LEAVE;
          end else if (at_k1 && wr_data == BYTE_KEY1) begin
            st_n = ST_KEY1;
          end
        end
        ST_KEY1: if (at_k2 && wr_data == BYTE_KEY2) st_n = ST_KEY2;
        ST_KEY2: begin
          if (at_k1) begin
            unique case (wr_data)
              OP_PROGRAM:   st_n = ST_PROG_DATA;
              OP_ERASE_SET: st_n = ST_ERS_SET;
              OP_FAST_IN:   fast_n = !ovl_q;
              OP_OVL_IN:    ovl_n = 1'b1;
              OP_LEAVE:     st_n = ST_OVL_LEAVE;
              default:      st_n = ST_READ;
            endcase
          end
        end
        ST_PROG_DATA: prog_go = 1'b1;
        ST_ERS_SET:   if (at_k1 && wr_data == BYTE_KEY1) st_n = ST_ERS_KEY1;
        ST_ERS_KEY1:  if (at_k2 && wr_data == BYTE_KEY2) st_n = ST_ERS_KEY2;
        ST_ERS_KEY2:  erase_go = at_k1 && (wr_data == OP_ERASE_ALL);
        ST_OVL_LEAVE: if (wr_data == OP_LEAVE_END) ovl_n = 1'b0;
        ST_FAST_LEAVE: if (wr_data == OP_LEAVE_END) fast_n = 1'b0;
        default: st_n = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_READ;
      ovl_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ovl_q  <= ovl_n;
      fast_q <= fast_n;
    end
  end

  assert_ignore_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(prog_go || erase_go));
  assert_modes_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_q |-> !ovl_q);
  assert_busy_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ovl_q == $past(ovl_q)) && (fast_q == $past(fast_q)));
endmodule

// File: rtl/nor_store.sv
module nor_store
  import nor_cmd_pkg::*;
#(
  parameter int unsigned MAW = 4,
  parameter int unsigned SAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_go,
  input  logic           erase_go,
  input  logic           ovl_mode,
  input  logic           done,
  input  logic [MAW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [MAW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data
);
  localparam int unsigned MW = 1 << MAW;
  localparam int unsigned SW = 1 << SAW;

  logic [DW-1:0]  main_q [MW];
  logic [DW-1:0]  sec_q  [SW];
  logic           pend_prog, pend_erase, pend_sec;
  logic [MAW-1:0] pend_idx;
  logic [DW-1:0]  pend_data;
  logic           prog_commit, erase_commit;

  assign prog_commit  = done && pend_prog;
  assign erase_commit = done && pend_erase;
  assign rd_data = ovl_mode ? sec_q[rd_idx[SAW-1:0]] : main_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MW; i++) main_q[i] <= '1;
      for (int j = 0; j < SW; j++) sec_q[j] <= '1;
      pend_prog  <= 1'b0;
      pend_erase <= 1'b0;
      pend_sec   <= 1'b0;
      pend_idx   <= '0;
      pend_data  <= '0;
    end else begin
      if (prog_go) begin
        pend_prog <= 1'b1;
        pend_sec  <= ovl_mode;
        pend_idx  <= wr_idx;
        pend_data <= wr_data;
      end
      if (erase_go) pend_erase <= 1'b1;
      if (prog_commit) begin
        pend_prog <= 1'b0;
        if (pend_sec)
          sec_q[pend_idx[SAW-1:0]] <= clear_only(sec_q[pend_idx[SAW-1:0]], pend_data);
        else
          main_q[pend_idx] <= clear_only(main_q[pend_idx], pend_data);
      end
      if (erase_commit) begin
        pend_erase <= 1'b0;
        for (int k = 0; k < MW; k++) main_q[k] <= '1;
      end
    end
  end

  assert_erase_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_commit |=> (main_q[MW-1] == '1) && (main_q[0] == '1));
  assert_single_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_prog && pend_erase));
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int unsigned AW           = 11,
  parameter int unsigned MAW          = 4,
  parameter int unsigned SAW          = 2,
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned ERASE_CYCLES = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [MAW-1:0] rd_addr,
  output logic [7:0]     rd_data,
  output logic           ready
);
  logic busy, done, prog_go, erase_go, ovl_mode, fast_mode;

  nor_seq_fsm #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .prog_go(prog_go), .erase_go(erase_go),
    .ovl_mode(ovl_mode), .fast_mode(fast_mode)
  );

  nor_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_prog(prog_go), .start_erase(erase_go),
    .busy(busy), .done(done)
  );

  nor_store #(.MAW(MAW), .SAW(SAW)) u_store (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
    .ovl_mode(ovl_mode), .done(done), .wr_idx(wr_addr[MAW-1:0]), .wr_data(wr_data),
    .rd_idx(rd_addr), .rd_data(rd_data)
  );

  assign ready = !busy;

  assert_fast_no_erase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_mode |-> !erase_go);
  assert_reset_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go) || $past(erase_go));
endmodule

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;
  localparam int AW = 11, MAW = 4, SAW = 2, PCYC = 8, ECYC = 32;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [MAW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic ready;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  nor_cmd_decoder #(.AW(AW), .MAW(MAW), .SAW(SAW), .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC))
    i_nor_cmd_decoder (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready));

  // behavioural reference
  int m_main[16], m_sec[4];
  bit m_ovl, m_fast;
  int m_busy, qa[$], qd[$];
  bit p_prog, p_erase, p_sec;
  int p_idx, p_data;

  function automatic int pat_len(int p);
    case (p) 0: return 4; 3: return 4; 4: return 6; default: return 3; endcase
  endfunction
  function automatic int pat_a(int p, int i);
    if (i == 1 || (p == 4 && i == 4)) return 'h2AA;
    if ((p == 0 || p == 3) && i == 3) return -1;
    return 'h555;
  endfunction
  function automatic int pat_d(int p, int i);
    if (i == 0 || (p == 4 && i == 3)) return 'hAA;
    if (i == 1 || (p == 4 && i == 4)) return 'h55;
    if (p == 4) return (i == 2) ? 'h80 : 'h10;
    if (p == 0) return (i == 2) ? 'hA0 : -1;
    if (p == 3) return (i == 2) ? 'h90 : 'h00;
    return (p == 1) ? 'h20 : 'h88;
  endfunction

  task automatic m_reset();
    foreach (m_main[i]) m_main[i] = 'hFF;
    foreach (m_sec[i]) m_sec[i] = 'hFF;
    m_ovl = 0; m_fast = 0; m_busy = 0; qa.delete(); qd.delete();
    p_prog = 0; p_erase = 0;
  endtask

  task automatic m_start_prog(int a, int d);
    p_prog = 1; p_sec = m_ovl; p_idx = a; p_data = d; m_busy = PCYC;
  endtask

  task automatic m_write(int a, int d);
    if (m_fast) begin
      if (qd.size() == 0) begin
        if (d == 'hA0 || d == 'h90) begin qa.push_back(a); qd.push_back(d); end
      end else begin
        if (qd[0] == 'hA0) m_start_prog(a, d);
        else if (d == 0) m_fast = 0;
        qa.delete(); qd.delete();
      end
    end else begin
      bit pre = 0;
      int full = -1;
      qa.push_back(a); qd.push_back(d);
      for (int p = 0; p < 5; p++) begin
        bit ok = 1;
        if (p == 1 && m_ovl) continue;
        if (qa.size() > pat_len(p)) continue;
        for (int i = 0; i < qa.size(); i++) begin
          if (pat_a(p, i) >= 0 && pat_a(p, i) != qa[i]) ok = 0;
          if (pat_d(p, i) >= 0 && pat_d(p, i) != qd[i]) ok = 0;
        end
        if (ok) begin pre = 1; if (qa.size() == pat_len(p)) full = p; end
      end
      case (full)
        0: m_start_prog(qa[3], qd[3]);
        1: m_fast = 1;
        2: m_ovl = 1;
        3: m_ovl = 0;
        4: begin p_erase = 1; m_busy = ECYC; end
        default: ;
      endcase
      if (full >= 0 || !pre) begin qa.delete(); qd.delete(); end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) begin
        if (p_prog) begin
          if (p_sec) m_sec[p_idx & 3] &= p_data; else m_main[p_idx & 15] &= p_data;
        end
        if (p_erase) foreach (m_main[i]) m_main[i] = 'hFF;
        p_prog = 0; p_erase = 0;
      end
    end else if (wr_en) m_write(int'(wr_addr), int'(wr_data));
    #2;
    if (rst_n) begin
      int exp_d;
      exp_d = m_ovl ? m_sec[int'(rd_addr) & 3] : m_main[int'(rd_addr)];
      checks++;
      if (ready !== (m_busy == 0)) begin
        errors++;
        $display("FAIL R9 model ready: actual %0b expected %0b", ready, m_busy == 0);
      end
      checks++;
      if (int'(rd_data) !== exp_d) begin
        errors++;
        $display("FAIL R2 model rd_data: actual %0h expected %0h", rd_data, exp_d);
      end
    end
  end

  task automatic chk(string tag, int act, int exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask
  task automatic unlock(); wr('h555, 'hAA); wr('h2AA, 'h55); endtask
  task automatic std_prog(int a, int d); unlock(); wr('h555, 'hA0); wr(a, d); endtask
  task automatic wait_ready(); while (!ready) @(negedge clk); endtask
  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask
  task automatic rd(string tag, int a, int exp_v);
    rd_addr = MAW'(a); #1; chk(tag, int'(rd_data), exp_v);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ready), 1);
    rd("R1 main word 3 erased", 3, 'hFF);

    std_prog(3, 'hA5);
    busy_len(n);
    chk("R9 program busy length", n, PCYC);
    rd("R2 programmed word", 3, 'hA5);

    std_prog(3, 'h5F); wait_ready();
    rd("R3 AND of old and new", 3, 'h05);

    unlock(); wr('h555, 'h20);
    wr('h000, 'hA0); wr(5, 'h3C); wait_ready();
    wr('h000, 'hA0); wr(6, 'hC3); wait_ready();
    rd("R4 fast program first", 5, 'h3C);
    rd("R4 fast program repeat", 6, 'hC3);

    wr('h555, 'h80); wr('h123, 'h55);
    wr('h000, 'hA0); wr(7, 'h0F); wait_ready();
    rd("R5 fast mode kept after stray bytes", 7, 'h0F);
    wr('h000, 'h90); wr('h000, 'h00);
    wr('h000, 'hA0); wr(8, 'h00); @(negedge clk);
    chk("R5 no busy after leaving fast mode", int'(ready), 1);
    rd("R5 A0 alone ignored after exit", 8, 'hFF);

    std_prog(9, 'h11);
    std_prog(10, 'h22);
    wait_ready();
    rd("R10 write during busy ignored", 10, 'hFF);
    rd("R10 first program kept", 9, 'h11);

    unlock(); wr('h555, 'h88); wr('h555, 'hAA);
    wr('h2AA, 'h55); wr('h555, 'h90); wr('h000, 'h00);
    rd("R10 overlay not entered while ... check main", 9, 'h11);

    wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr(11, 'h00);
    @(negedge clk);
    chk("R11 mismatch no busy", int'(ready), 1);
    rd("R11 mismatch aborts sequence", 11, 'hFF);

    unlock(); wr('h555, 'h88);
    rd("R6 overlay reads secured region", 1, 'hFF);
    std_prog(1, 'h77); wait_ready();
    rd("R6 program goes to secured word", 1, 'h77);
    unlock(); wr('h555, 'h20); wr('h000, 'hA0); wr(2, 'h00);
    @(negedge clk);
    chk("R7 fast entry rejected no busy", int'(ready), 1);
    rd("R7 secured word untouched", 2, 'hFF);
    unlock(); wr('h555, 'h90); wr('h000, 'h00);
    rd("R6 main word 1 untouched", 1, 'hFF);
    rd("R6 main reads after exit", 3, 'h05);
    unlock(); wr('h555, 'h88);
    rd("R6 secured contents persist", 1, 'h77);
    unlock(); wr('h555, 'h90); wr('h000, 'h00);

    unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10);
    busy_len(n);
    chk("R9 erase busy length", n, ECYC);
    rd("R8 erased word 3", 3, 'hFF);
    rd("R8 erased word 5", 5, 'hFF);

    std_prog(4, 'h00);
    @(negedge clk); @(negedge clk);
    chk("R12 busy before reset", int'(ready), 0);
    rst_n = 0; #1;
    chk("R12 reset aborts busy", int'(ready), 1);
    @(negedge clk); rst_n = 1; @(negedge clk);
    rd("R12 read mode after reset", 4, 'hFF);
    std_prog(12, 'h81); wait_ready();
    rd("R12 commands accepted after reset", 12, 'h81);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule